// File: doc/BRIEF.md
# Packed Saturating Rounding Doubling Multiply-Accumulate Unit

This unit performs signed fixed-point multiply-accumulate and multiply-subtract on packed vectors, keeping the high half of the result. For every lane it multiplies two signed elements and doubles the product. It adds this to, or subtracts it from, the accumulator element placed in the upper half of a double-width word. It then rounds and keeps the upper half, saturating when the value leaves the lane's signed range. The lanes are 16 or 32 bits wide and all of them work in parallel. Any saturating lane sets a sticky flag, and only an explicit clear input resets that flag.

The vector is split into 8-byte granules. An active-size count and a maximum-size count, both given in granules, select the part of the result that is computed and the part that is forced to zero. The unit takes one operation through an input valid/ready handshake. The registered result appears one cycle later behind an output valid/ready handshake.

A two-state controller runs the unit. In state IDLE, `in_ready` is high. The transition ACCEPT (`in_valid` high in IDLE) registers the result and moves to HOLD. In HOLD, `out_valid` is high and the result is frozen. The transition RELEASE (`out_ready` high in HOLD) returns to IDLE. While HOLD lasts with `out_ready` low, the state stays HOLD.

Top module: `sqrdm_mac_lane`

## Requirements
- R1: With `elem32`=0, each 16-bit lane k takes a=src_a[16k+15:16k], b=src_b[16k+15:16k] and c=src_acc[16k+15:16k]. The lane computes ((c<<15) + a*b + (1<<14)) >>> 15 as a signed value of 32 bits or more. It returns this value when it fits in 16 signed bits.
- R2: With `do_sub`=1, the lane computes ((c<<15) − a*b + (1<<14)) >>> 15 with the same precision and shift.
- R3: With `elem32`=1, the 32-bit lanes j (bits 32j+31:32j) use a shift of 31 and a rounding constant of 1<<30, with at least 64-bit intermediate precision.
- R4: When the shifted value does not fit the lane's signed range, the lane returns the most negative value if the intermediate sum is negative and the most positive value otherwise (0x8000/0x7FFF for 16-bit lanes, 0x80000000/0x7FFFFFFF for 32-bit lanes).
- R5: `sat_flag` is set when an accepted operation has at least one active lane that saturates. An operation without saturation never clears it, and it rises only on an accepted operation.
- R6: A cycle with `sat_clear` high resets `sat_flag`. If an accepted operation in that same cycle saturates, the flag is set.
- R7: The result keeps each lane in the same bit positions as its operands. A lane's result depends only on that lane's operands.
- R8: Let E = min(`act_gran`, `max_gran`). Granules g (bits 64g+63:64g) with E ≤ g < `max_gran` are zero in the result. Lanes in those granules never set `sat_flag`.
- R9: Granules g ≥ `max_gran` return the accumulator bits `src_acc` unchanged.
- R10: An operation is accepted when `in_valid` and `in_ready` are both high. `out_valid` goes high on the next cycle. `result` and `out_valid` stay stable, and `in_ready` stays low, until `out_ready` is high.
- R11: After reset, `in_ready`=1, `out_valid`=0, `sat_flag`=0 and `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation (IDLE) |
| elem32 | input | 1 | Lane width: 0 = 16-bit lanes, 1 = 32-bit lanes |
| do_sub | input | 1 | 0 = accumulate, 1 = subtract the doubled product |
| act_gran | input | CW (3) | Active size in 8-byte granules |
| max_gran | input | CW (3) | Maximum size in 8-byte granules |
| src_a | input | VEC_BITS (256) | Multiplicand vector |
| src_b | input | VEC_BITS (256) | Multiplier vector |
| src_acc | input | VEC_BITS (256) | Accumulator vector |
| sat_clear | input | 1 | Reset the sticky saturation flag |
| out_valid | output | 1 | Result held (HOLD) |
| out_ready | input | 1 | Consumer takes the result |
| result | output | VEC_BITS (256) | Result vector |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The bench drives the extreme operand pairs. The pair −32768 × −32768 with a maximum accumulator must saturate high, and the mirrored subtract must saturate low. A design that truncates instead of clamping would wrap to the opposite sign, and one that takes the clamp direction from the wrong bit would pick the wrong bound. Rounding at the half-step boundary is exercised through mixed random lanes. A missing or misplaced rounding constant shows up as results that are off by one.

For the size controls, the bench places saturating operands only in lanes beyond the active size. A unit that lets those lanes set the flag, or that zeroes or computes past the maximum size instead of passing the accumulator through, fails there.

The bench also holds back the output with a stalling consumer. A unit whose result changes during the stall, or that accepts a new operation early, is caught. It also covers a clear that arrives together with a saturating operation: that case must leave the flag set.

// File: rtl/sqrdm_pkg.sv
`timescale 1ns/1ps
package sqrdm_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } ctl_state_e;

    typedef enum logic {
        LW_16 = 1'b0,
        LW_32 = 1'b1
    } lane_w_e;

    localparam int GRAN_BITS = 64;
endpackage

// File: rtl/sqrdm_lane.sv
`timescale 1ns/1ps
// One signed lane: doubled, rounded product fused with the accumulator,
// high half kept with saturation.
module sqrdm_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] acc,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         sat
);
    localparam int P = 2 * W + 2;

    logic signed [W-1:0]   a_s;
    logic signed [W-1:0]   b_s;
    logic signed [2*W-1:0] prod;
    logic signed [P-1:0]   acc_x;
    logic signed [P-1:0]   prod_x;
    logic signed [P-1:0]   rnd;
    logic signed [P-1:0]   sum;
    logic signed [P-1:0]   sh;
    logic                  fits;

    always_comb begin
        a_s    = a;
        b_s    = b;
        prod   = a_s * b_s;
        // accumulator pre-shifted by W-1, product left single: same as
        // doubling the product and shifting the accumulator by W
        acc_x  = {{3{acc[W-1]}}, acc, {(W-1){1'b0}}};
        prod_x = {{2{prod[2*W-1]}}, prod};
        rnd    = {{(P-W+1){1'b0}}, 1'b1, {(W-2){1'b0}}};
        sum    = sub ? (acc_x - prod_x + rnd) : (acc_x + prod_x + rnd);
        sh     = sum >>> (W - 1);
        fits   = (&sh[P-1:W-1]) | ~(|sh[P-1:W-1]);
        sat    = ~fits;
        if (fits) begin
            res = sh[W-1:0];
        end else if (sh[P-1]) begin
            res = {1'b1, {(W-1){1'b0}}};
        end else begin
            res = {1'b0, {(W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/sqrdm_span.sv
`timescale 1ns/1ps
// Granule classification: computed, zeroed, or passed through.
module sqrdm_span #(
    parameter int GRAN = 4,
    parameter int CW   = 3
) (
    input  logic [CW-1:0]   act_gran,
    input  logic [CW-1:0]   max_gran,
    output logic [GRAN-1:0] act_mask,
    output logic [GRAN-1:0] live_mask
);
    logic [CW-1:0] eff;

    always_comb begin
        eff = (act_gran < max_gran) ? act_gran : max_gran;
    end

    for (genvar g = 0; g < GRAN; g++) begin : g_gran
        assign act_mask[g]  = (CW'(g) < eff);
        assign live_mask[g] = (CW'(g) < max_gran);
    end
endmodule

// File: rtl/sqrdm_core.sv
`timescale 1ns/1ps
// Parallel lane array for both widths, lane select and granule merge.
module sqrdm_core
    import sqrdm_pkg::*;
#(
    parameter int VEC_BITS = 256
) (
    input  logic [VEC_BITS-1:0]           src_a,
    input  logic [VEC_BITS-1:0]           src_b,
    input  logic [VEC_BITS-1:0]           src_acc,
    input  lane_w_e                       lane_w,
    input  logic                          do_sub,
    input  logic [VEC_BITS/GRAN_BITS-1:0] act_mask,
    input  logic [VEC_BITS/GRAN_BITS-1:0] live_mask,
    output logic [VEC_BITS-1:0]           res,
    output logic                          sat_any
);
    localparam int GRAN  = VEC_BITS / GRAN_BITS;
    localparam int N16   = VEC_BITS / 16;
    localparam int N32   = VEC_BITS / 32;
    localparam int PER16 = GRAN_BITS / 16;
    localparam int PER32 = GRAN_BITS / 32;

    logic [VEC_BITS-1:0] r16;
    logic [VEC_BITS-1:0] r32;
    logic [N16-1:0]      s16;
    logic [N32-1:0]      s32;
    logic [N16-1:0]      a16;
    logic [N32-1:0]      a32;

    for (genvar i = 0; i < N16; i++) begin : g_l16
        sqrdm_lane #(.W(16)) u_lane (
            .a   (src_a[16*i +: 16]),
            .b   (src_b[16*i +: 16]),
            .acc (src_acc[16*i +: 16]),
            .sub (do_sub),
            .res (r16[16*i +: 16]),
            .sat (s16[i])
        );
        assign a16[i] = act_mask[i / PER16];
    end

    for (genvar j = 0; j < N32; j++) begin : g_l32
        sqrdm_lane #(.W(32)) u_lane (
            .a   (src_a[32*j +: 32]),
            .b   (src_b[32*j +: 32]),
            .acc (src_acc[32*j +: 32]),
            .sub (do_sub),
            .res (r32[32*j +: 32]),
            .sat (s32[j])
        );
        assign a32[j] = act_mask[j / PER32];
    end

    always_comb begin
        if (lane_w == LW_32) begin
            sat_any = |(s32 & a32);
        end else begin
            sat_any = |(s16 & a16);
        end
    end

    for (genvar g = 0; g < GRAN; g++) begin : g_merge
        always_comb begin
            if (act_mask[g]) begin
                res[GRAN_BITS*g +: GRAN_BITS] = (lane_w == LW_32)
                    ? r32[GRAN_BITS*g +: GRAN_BITS]
                    : r16[GRAN_BITS*g +: GRAN_BITS];
            end else if (live_mask[g]) begin
                res[GRAN_BITS*g +: GRAN_BITS] = '0;
            end else begin
                res[GRAN_BITS*g +: GRAN_BITS] = src_acc[GRAN_BITS*g +: GRAN_BITS];
            end
        end
    end
endmodule

// File: rtl/sqrdm_mac_lane.sv
`timescale 1ns/1ps
// Top: handshake controller, result register and sticky flag.
module sqrdm_mac_lane
    import sqrdm_pkg::*;
#(
    parameter int VEC_BITS = 256,
    localparam int GRAN    = VEC_BITS / GRAN_BITS,
    localparam int CW      = $clog2(GRAN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic                elem32,
    input  logic                do_sub,
    input  logic [CW-1:0]       act_gran,
    input  logic [CW-1:0]       max_gran,
    input  logic [VEC_BITS-1:0] src_a,
    input  logic [VEC_BITS-1:0] src_b,
    input  logic [VEC_BITS-1:0] src_acc,
    input  logic                sat_clear,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [VEC_BITS-1:0] result,
    output logic                sat_flag
);
    ctl_state_e          state_q;
    ctl_state_e          state_d;
    lane_w_e             lane_w;
    logic [GRAN-1:0]     act_mask;
    logic [GRAN-1:0]     live_mask;
    logic [VEC_BITS-1:0] core_res;
    logic                core_sat;
    logic                accept;
    logic [VEC_BITS-1:0] res_q;
    logic                flag_q;

    assign lane_w = lane_w_e'(elem32);

    sqrdm_span #(.GRAN(GRAN), .CW(CW)) u_span (
        .act_gran  (act_gran),
        .max_gran  (max_gran),
        .act_mask  (act_mask),
        .live_mask (live_mask)
    );

    sqrdm_core #(.VEC_BITS(VEC_BITS)) u_core (
        .src_a     (src_a),
        .src_b     (src_b),
        .src_acc   (src_acc),
        .lane_w    (lane_w),
        .do_sub    (do_sub),
        .act_mask  (act_mask),
        .live_mask (live_mask),
        .res       (core_res),
        .sat_any   (core_sat)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_HOLD;
            ST_HOLD: if (out_ready) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs of the controller
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready  = 1'b1;
            ST_HOLD: out_valid = 1'b1;
        endcase
    end

    assign accept = in_valid & in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (accept) begin
                res_q <= core_res;
            end
            flag_q <= (flag_q & ~sat_clear) | (accept & core_sat);
        end
    end

    assign result   = res_q;
    assign sat_flag = flag_q;
endmodule

// File: rtl/sqrdm_chk.sv
`timescale 1ns/1ps
module sqrdm_chk
    import sqrdm_pkg::*;
#(
    parameter int VEC_BITS = 256,
    localparam int GRAN    = VEC_BITS / GRAN_BITS,
    localparam int CW      = $clog2(GRAN + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic [CW-1:0]       act_gran,
    input logic [CW-1:0]       max_gran,
    input logic                sat_clear,
    input logic                out_valid,
    input logic                out_ready,
    input logic [VEC_BITS-1:0] result,
    input logic                sat_flag
);
    logic [CW-1:0]       cap_act;
    logic [CW-1:0]       cap_max;
    logic [VEC_BITS-1:0] tail_mask;
    logic [CW-1:0]       cap_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_act <= '0;
            cap_max <= '0;
        end else if (in_valid && in_ready) begin
            cap_act <= act_gran;
            cap_max <= max_gran;
        end
    end

    always_comb begin
        cap_eff = (cap_act < cap_max) ? cap_act : cap_max;
        for (int g = 0; g < GRAN; g++) begin
            tail_mask[GRAN_BITS*g +: GRAN_BITS] =
                ((CW'(g) >= cap_eff) && (CW'(g) < cap_max)) ? '1 : '0;
        end
    end

    p_accept_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(result) && !in_ready));

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !sat_clear) |=> sat_flag);

    p_rise_on_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_flag && !(in_valid && in_ready)) |=> !sat_flag);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_clear && !(in_valid && in_ready)) |=> !sat_flag);

    p_tail_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((result & tail_mask) == '0));
endmodule

bind sqrdm_mac_lane sqrdm_chk #(.VEC_BITS(VEC_BITS)) u_chk (.*);

// File: tb/test_sqrdm_mac_lane.sv
`timescale 1ns/1ps
module test_sqrdm_mac_lane;
    localparam int VB = 256;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          elem32 = 1'b0;
    logic          do_sub = 1'b0;
    logic [CW-1:0] act_gran = 3'd4;
    logic [CW-1:0] max_gran = 3'd4;
    logic [VB-1:0] src_a = '0;
    logic [VB-1:0] src_b = '0;
    logic [VB-1:0] src_acc = '0;
    logic          sat_clear = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [VB-1:0] result;
    logic          sat_flag;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  exp_flag = 1'b0;
    bit  stall_en = 1'b0;

    typedef struct {
        logic [VB-1:0] v;
        bit            f;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    sqrdm_mac_lane #(.VEC_BITS(VB)) i_sqrdm_mac_lane (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .elem32(elem32), .do_sub(do_sub), .act_gran(act_gran), .max_gran(max_gran),
        .src_a(src_a), .src_b(src_b), .src_acc(src_acc), .sat_clear(sat_clear),
        .out_valid(out_valid), .out_ready(out_ready), .result(result), .sat_flag(sat_flag)
    );

    task automatic chk(bit ok, string req, logic [VB-1:0] act, logic [VB-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // independent lane model, wide arithmetic
    function automatic logic [31:0] lane_ref(int w, logic [31:0] a, logic [31:0] b,
                                             logic [31:0] c, bit sub, output bit sat);
        logic signed [95:0] av, bv, cv, s, r, hi, lo;
        if (w == 16) begin
            av = {{80{a[15]}}, a[15:0]};
            bv = {{80{b[15]}}, b[15:0]};
            cv = {{80{c[15]}}, c[15:0]};
            hi = 96'sd32767;
        end else begin
            av = {{64{a[31]}}, a};
            bv = {{64{b[31]}}, b};
            cv = {{64{c[31]}}, c};
            hi = 96'sd2147483647;
        end
        lo = -hi - 96'sd1;
        s = (cv <<< (w - 1)) + (sub ? -(av * bv) : (av * bv)) + (96'sd1 <<< (w - 2));
        r = s >>> (w - 1);
        sat = (r > hi) || (r < lo);
        if (r > hi)      r = hi;
        else if (r < lo) r = lo;
        return (w == 16) ? {16'h0, r[15:0]} : r[31:0];
    endfunction

    function automatic logic [VB-1:0] vec_ref(logic [VB-1:0] a, logic [VB-1:0] b,
            logic [VB-1:0] c, bit e32, bit sub, int act, int mx, output bit sat_any);
        logic [VB-1:0] o;
        int eff, w, n;
        bit s;
        eff = (act < mx) ? act : mx;
        w = e32 ? 32 : 16;
        n = VB / w;
        sat_any = 0;
        o = c;
        for (int k = 0; k < n; k++) begin
            int g;
            logic [31:0] r;
            g = (k * w) / 64;
            r = lane_ref(w, a[w*k +: 32], b[w*k +: 32], c[w*k +: 32], sub, s);
            if (g < eff) begin
                if (w == 16) o[16*k +: 16] = r[15:0];
                else         o[32*k +: 32] = r;
                sat_any |= s;
            end else if (g < mx) begin
                if (w == 16) o[16*k +: 16] = '0;
                else         o[32*k +: 32] = '0;
            end
        end
        return o;
    endfunction

    task automatic send(string tag, logic [VB-1:0] a, logic [VB-1:0] b, logic [VB-1:0] c,
                        bit e32, bit sub, int act, int mx, bit clr);
        exp_t it;
        bit s;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        it.v = vec_ref(a, b, c, e32, sub, act, mx, s);
        exp_flag = (exp_flag & ~clr) | s;
        it.f = exp_flag;
        it.tag = tag;
        sb.push_back(it);
        src_a = a; src_b = b; src_acc = c; elem32 = e32; do_sub = sub;
        act_gran = CW'(act); max_gran = CW'(mx); sat_clear = clr; in_valid = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        sat_clear = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (sb.size() != 0 || out_valid) @(negedge clk);
    endtask

    function automatic logic [VB-1:0] rnd_vec();
        logic [VB-1:0] v;
        for (int k = 0; k < VB / 32; k++) v[32*k +: 32] = $urandom;
        return v;
    endfunction

    // monitor: pops the scoreboard when a result is taken
    initial begin
        forever begin
            @(negedge clk);
            if (out_valid && out_ready) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R10 unexpected result", result, '0);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    chk(result == it.v, it.tag, result, it.v);
                    chk(sat_flag == it.f, {it.tag, " R5 flag"},
                        VB'(sat_flag), VB'(it.f));
                end
            end
        end
    end

    // hold monitor: result frozen and input blocked during a stall
    initial begin
        logic [VB-1:0] held;
        bit was_stalled;
        was_stalled = 0;
        held = '0;
        forever begin
            @(negedge clk);
            if (out_valid && was_stalled) begin
                chk(result == held, "R10 hold stable", result, held);
                chk(in_ready == 1'b0, "R10 in_ready low in hold", VB'(in_ready), '0);
            end
            was_stalled = out_valid && !out_ready;
            held = result;
        end
    end

    // consumer: stalls at random when enabled
    initial begin
        forever begin
            @(posedge clk);
            #1;
            out_ready = stall_en ? (($urandom % 3) == 0) : 1'b1;
        end
    end

    // watchdog
    initial begin
        #400000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [VB-1:0] va, vb, vc;
        bit s;
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk(in_ready == 1'b1, "R11 in_ready", VB'(in_ready), VB'(1));
        chk(out_valid == 1'b0, "R11 out_valid", VB'(out_valid), '0);
        chk(sat_flag == 1'b0, "R11 sat_flag", VB'(sat_flag), '0);
        chk(result == '0, "R11 result", result, '0);
        rst_n = 1'b1;

        // R1 R7 16-bit accumulate, distinct lanes
        send("R1 R7 16b acc", rnd_vec() >> 1 & {16{16'h3fff}}, rnd_vec() & {16{16'h3fff}},
             rnd_vec() & {16{16'h0fff}}, 0, 0, 4, 4, 0);
        // R7 only lane 1 populated
        va = '0; vb = '0; vc = '0;
        va[31:16] = 16'h1234; vb[31:16] = 16'h0456; vc[31:16] = 16'h0101;
        send("R7 lane position", va, vb, vc, 0, 0, 4, 4, 0);
        // R2 16-bit subtract
        send("R2 16b sub", rnd_vec() & {16{16'h3fff}}, rnd_vec() & {16{16'h3fff}},
             rnd_vec() & {16{16'h0fff}}, 0, 1, 4, 4, 0);
        // R3 32-bit both ways
        send("R3 32b acc", rnd_vec() & {8{32'h3fffffff}}, rnd_vec() & {8{32'h3fffffff}},
             rnd_vec() & {8{32'h0fffffff}}, 1, 0, 4, 4, 0);
        send("R3 32b sub", rnd_vec() & {8{32'h3fffffff}}, rnd_vec() & {8{32'h3fffffff}},
             rnd_vec() & {8{32'h0fffffff}}, 1, 1, 4, 4, 0);
        drain();
        chk(sat_flag == 1'b0, "R5 no saturation yet", VB'(sat_flag), '0);

        // R4 positive saturation 16-bit, negative saturation by subtract
        send("R4 16b sat high", {16{16'h8000}}, {16{16'h8000}}, {16{16'h7fff}}, 0, 0, 4, 4, 0);
        send("R4 16b sat low", {16{16'h8000}}, {16{16'h8000}}, {16{16'h8000}}, 0, 1, 4, 4, 0);
        send("R4 32b sat high", {8{32'h80000000}}, {8{32'h80000000}}, {8{32'h7fffffff}},
             1, 0, 4, 4, 0);
        // R5 flag stays after a clean op
        send("R5 sticky after clean op", '0, '0, rnd_vec(), 0, 0, 4, 4, 0);
        drain();

        // R6 clear alone
        @(negedge clk);
        sat_clear = 1'b1;
        @(posedge clk);
        #1;
        sat_clear = 1'b0;
        exp_flag = 1'b0;
        @(negedge clk);
        chk(sat_flag == 1'b0, "R6 clear", VB'(sat_flag), '0);

        // R8 saturating operands only in inactive-but-live granules
        va = '0; vb = '0; vc = '0;
        va[255:128] = {8{16'h8000}}; vb[255:128] = {8{16'h8000}}; vc[255:128] = {8{16'h7fff}};
        va[15:0] = 16'h0100; vb[15:0] = 16'h0200;
        send("R8 tail zero no flag", va, vb, vc, 0, 0, 2, 4, 0);
        drain();
        chk(sat_flag == 1'b0, "R8 inactive lanes no flag", VB'(sat_flag), '0);

        // R9 pass-through beyond max, with act > max clamped
        send("R9 passthrough", rnd_vec() & {16{16'h3fff}}, rnd_vec() & {16{16'h3fff}},
             rnd_vec(), 0, 0, 4, 1, 0);
        send("R8 R9 act0 max3", rnd_vec(), rnd_vec(), rnd_vec(), 1, 1, 0, 3, 0);

        // R6 clear with saturating accept in the same cycle
        send("R6 R4 clear+sat", {8{32'h80000000}}, {8{32'h80000000}}, {8{32'h80000000}},
             1, 1, 4, 4, 1);
        drain();
        chk(sat_flag == 1'b1, "R6 set wins over clear", VB'(sat_flag), VB'(1));

        // R10 random stream under a stalling consumer
        stall_en = 1'b1;
        for (int t = 0; t < 60; t++) begin
            send("R10 R1 R2 R3 random", rnd_vec(), rnd_vec(), rnd_vec(),
                 bit'($urandom % 2), bit'($urandom % 2),
                 int'($urandom % 5), int'($urandom % 5), bit'($urandom % 4 == 0));
        end
        drain();
        stall_en = 1'b0;
        s = 0;
        drain();

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule